// File: doc/BRIEF.md
# SD host single-address DMA engine with boundary pause

This block is the single-address DMA engine of an SD host controller. Software programs a start address, a block size with a boundary code, a block count, and a transfer mode through a simple register write port. Starting the transfer makes the engine walk through system memory one data word at a time. For each word it issues a request carrying the word address, the byte lanes to use, and the direction. The memory side accepts each request with a ready handshake. The card-side data lines, CRC and the memory bus protocol sit outside this block.

The engine does not run straight through the buffer. Each time the running address reaches a multiple of the programmed power-of-two boundary while data is still left, it stops issuing requests and raises a DMA interrupt flag. It then waits until software writes a new address, and resumes from there. When the last word of the last block is accepted, it raises a transfer-complete flag. Both flags are cleared by writing a one to them.

Top module: `sdma_bound_engine`

## Requirements
- R1: After reset, no request is issued, `busy`, `dmaIntFlag` and `xferDoneFlag` are 0, and `blocksLeft` is 0.
- R2: The register offsets are as follows.
  - Offset 0: address.
  - Offset 1: configuration, with the block size in bytes at bits [11:0] and the boundary code at bits [14:12].
  - Offset 2: block count, at bits [15:0].
  - Offset 3: mode. Bit 0 starts the transfer, bit 1 enables counting, bit 4 sets direction, bit 5 selects multi-block.
  - Offset 4: host control, with the DMA select field at bits [4:3].
  - Offset 5: interrupt status, with bit 0 for transfer complete and bit 1 for DMA interrupt.
  A mode write with bit 0 set while idle starts a transfer.
- R3: Requests go to consecutive word addresses, 4 bytes apart, from the programmed address with bits [1:0] cleared. The address advances only when a request is accepted (valid and ready together).
- R4: The byte strobe is 4'b1111, except on the last word of a block whose size modulo 4 is k, with k nonzero. That word uses the low k lanes, for example 4'b0011 for k = 2.
- R5: `memReqWrite` equals mode bit 4: 1 when the card is read and memory is written, 0 otherwise.
- R6: Boundary code n sets a boundary of 4096 << n bytes. When an accepted word leaves the next address on a boundary and data is still left, the engine pauses with `dmaIntFlag` set and issues no requests.
- R7: While paused, a write to the address register resumes the transfer from the written address. The position within the current block is kept.
- R8: With counting and multi-block both enabled, the count decreases after each block, and the transfer ends when it reaches 0. `blocksLeft` shows the count.
- R9: With counting disabled, exactly one block moves and the count is left unchanged.
- R10: Starting with counting enabled and a count of 0 sets `xferDoneFlag` at once and issues no request.
- R11: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged.
- R12: A start while the DMA select field is not 00 is ignored: the engine does not become busy, makes no request and sets no flag.
- R13: While busy, writes to the configuration, count, mode and host control registers are ignored. While running, address writes are ignored.
- R14: A transfer whose last word ends exactly on a boundary sets `xferDoneFlag` and does not set `dmaIntFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register offset |
| regWrData | input | 32 | Register write data |
| memReqValid | output | 1 | Word request valid |
| memReqReady | input | 1 | Memory side accepts the request |
| memReqAddr | output | 32 | Word address of the request |
| memReqStrb | output | 4 | Byte lanes used by the request |
| memReqWrite | output | 1 | 1 = memory is written (card read) |
| blocksLeft | output | 16 | Current block count |
| busy | output | 1 | Transfer running or paused |
| dmaIntFlag | output | 1 | Boundary interrupt status |
| xferDoneFlag | output | 1 | Transfer complete status |

## Verification
The assertions assume the following about the block's inputs:
- The block size is never zero.
- `memReqReady` is only meaningful while a request is valid.
- A register write lasts exactly one cycle.

The stimulus always programs nonzero sizes and drives every write through a single-cycle task. Ready is held high, alternated, or held low from the bench clock's falling edge. Start addresses are placed a few words below 4 KiB, 8 KiB and 512 KiB boundaries. This makes pauses and boundary-aligned endings occur within a handful of requests.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam logic [2:0] OFS_ADDR    = 3'd0;
  localparam logic [2:0] OFS_CFG     = 3'd1;
  localparam logic [2:0] OFS_COUNT   = 3'd2;
  localparam logic [2:0] OFS_MODE    = 3'd3;
  localparam logic [2:0] OFS_HOSTCTL = 3'd4;
  localparam logic [2:0] OFS_INT     = 3'd5;

  localparam int MODE_START_BIT = 0;
  localparam int MODE_CNTEN_BIT = 1;
  localparam int MODE_DIR_BIT   = 4;
  localparam int MODE_MULTI_BIT = 5;
  localparam int INT_DONE_BIT   = 0;
  localparam int INT_DMA_BIT    = 1;
  localparam int DMASEL_LSB     = 3;
  localparam int BND_CODE_LSB   = 12;
  localparam int BND_CODE_W     = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } engState_t;

  typedef struct packed {
    logic busy;
    logic running;
    logic accept;
  } ctlStrobe_t;

  typedef struct packed {
    logic startReq;
    logic startZero;
    logic addrWrite;
    logic lastWord;
    logic lastBlock;
    logic crossBnd;
    logic clrDone;
    logic clrDma;
  } dpStatus_t;

endpackage

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int BSIZE_W    = 12,
  parameter int CNT_W      = 16,
  parameter int BND_BASE   = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [2:0]            regWrAddr,
  input  logic [ADDR_W-1:0]     regWrData,
  input  ctlStrobe_t            ctl,
  output dpStatus_t             status,
  output logic [ADDR_W-1:0]     curAddr,
  output logic [DATA_BYTES-1:0] strb,
  output logic                  dirRead,
  output logic [CNT_W-1:0]      blocksLeft
);

  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int WIDX_W = BSIZE_W - LANE_W;

  logic [ADDR_W-1:0]     curAddr_q;
  logic [BSIZE_W-1:0]    blkSize_q;
  logic [BND_CODE_W-1:0] bndCode_q;
  logic [CNT_W-1:0]      count_q;
  logic                  cntEn_q;
  logic                  dirRead_q;
  logic                  multi_q;
  logic [1:0]            dmaSel_q;
  logic [WIDX_W-1:0]     wordIdx_q;

  logic wrAddr, wrCfg, wrCount, wrMode, wrHost, wrInt;
  assign wrAddr  = regWrEn && (regWrAddr == OFS_ADDR);
  assign wrCfg   = regWrEn && (regWrAddr == OFS_CFG);
  assign wrCount = regWrEn && (regWrAddr == OFS_COUNT);
  assign wrMode  = regWrEn && (regWrAddr == OFS_MODE);
  assign wrHost  = regWrEn && (regWrAddr == OFS_HOSTCTL);
  assign wrInt   = regWrEn && (regWrAddr == OFS_INT);

  // Index of the final word in a block
  logic [BSIZE_W-1:0] sizeM1;
  logic [WIDX_W-1:0]  lastWordIdx;
  logic               lastWord;
  logic               unusedSize;
  assign sizeM1      = blkSize_q - BSIZE_W'(1);
  assign lastWordIdx = sizeM1[BSIZE_W-1:LANE_W];
  assign lastWord    = (wordIdx_q == lastWordIdx);
  assign unusedSize  = ^sizeM1[LANE_W-1:0];

  // Boundary detection on the address following the current word
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] bndMask;
  assign nextAddr = curAddr_q + ADDR_W'(DATA_BYTES);
  assign bndMask  = (ADDR_W'(1) << (BND_BASE + int'(bndCode_q))) - ADDR_W'(1);

  // Byte lanes: partial only on the tail word of a block
  logic [LANE_W-1:0] sizeTail;
  assign sizeTail = blkSize_q[LANE_W-1:0];
  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign strb[g] = !lastWord || (sizeTail == '0) || (LANE_W'(g) < sizeTail);
  end

  always_comb begin
    status.startReq  = wrMode && regWrData[MODE_START_BIT] && !ctl.busy && (dmaSel_q == 2'b00);
    status.startZero = regWrData[MODE_CNTEN_BIT] && (count_q == '0);
    status.addrWrite = wrAddr;
    status.lastWord  = lastWord;
    status.lastBlock = !cntEn_q || !multi_q || (count_q == CNT_W'(1));
    status.crossBnd  = ((nextAddr & bndMask) == '0);
    status.clrDone   = wrInt && regWrData[INT_DONE_BIT];
    status.clrDma    = wrInt && regWrData[INT_DMA_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr_q <= '0;
      blkSize_q <= '0;
      bndCode_q <= '0;
      count_q   <= '0;
      cntEn_q   <= 1'b0;
      dirRead_q <= 1'b0;
      multi_q   <= 1'b0;
      dmaSel_q  <= 2'b00;
      wordIdx_q <= '0;
    end else begin
      if (wrAddr && !ctl.running)
        curAddr_q <= {regWrData[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      else if (ctl.accept)
        curAddr_q <= nextAddr;

      if (wrCfg && !ctl.busy) begin
        blkSize_q <= regWrData[BSIZE_W-1:0];
        bndCode_q <= regWrData[BND_CODE_LSB +: BND_CODE_W];
      end

      if (wrCount && !ctl.busy)
        count_q <= regWrData[CNT_W-1:0];
      else if (ctl.accept && lastWord && cntEn_q && (count_q != '0))
        count_q <= count_q - CNT_W'(1);

      if (wrMode && !ctl.busy) begin
        cntEn_q   <= regWrData[MODE_CNTEN_BIT];
        dirRead_q <= regWrData[MODE_DIR_BIT];
        multi_q   <= regWrData[MODE_MULTI_BIT];
      end

      if (wrHost && !ctl.busy)
        dmaSel_q <= regWrData[DMASEL_LSB +: 2];

      if (status.startReq)
        wordIdx_q <= '0;
      else if (ctl.accept)
        wordIdx_q <= lastWord ? '0 : wordIdx_q + WIDX_W'(1);
    end
  end

  assign curAddr    = curAddr_q;
  assign dirRead    = dirRead_q;
  assign blocksLeft = count_q;

  // R3: each accepted word moves the address one word forward
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> curAddr_q == $past(curAddr_q) + ADDR_W'(DATA_BYTES));

  // R13: a running transfer without acceptance holds its address, whatever is written
  a_r13_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.running && !ctl.accept) |=> $stable(curAddr_q));

  // R4: a live request always uses at least one byte lane
  a_r4_strb_live: assert property (@(posedge clk) disable iff (!rstN)
    ctl.running |-> $countones(strb) != 0);

  // R8: the count never grows while a transfer is in progress
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && $past(ctl.busy)) |-> count_q <= $past(count_q));

endmodule

// File: rtl/sdma_control.sv
module sdma_control
  import sdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  input  logic       memReqReady,
  output ctlStrobe_t ctl,
  output logic       memReqValid,
  output logic       busy,
  output logic       dmaIntFlag,
  output logic       xferDoneFlag
);

  engState_t state_q, state_d;
  logic      setDone, setDma;
  logic      accept;
  logic      done_q, dma_q;

  assign accept = (state_q == ST_RUN) && memReqReady;

  always_comb begin
    state_d = state_q;
    setDone = 1'b0;
    setDma  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (status.startReq) begin
          if (status.startZero) setDone = 1'b1;
          else                  state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (accept) begin
          if (status.lastWord && status.lastBlock) begin
            state_d = ST_IDLE;
            setDone = 1'b1;
          end else if (status.crossBnd) begin
            state_d = ST_PAUSE;
            setDma  = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        if (status.addrWrite) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (done_q && !status.clrDone) || setDone;
      dma_q   <= (dma_q && !status.clrDma) || setDma;
    end
  end

  assign ctl.busy     = (state_q != ST_IDLE);
  assign ctl.running  = (state_q == ST_RUN);
  assign ctl.accept   = accept;
  assign memReqValid  = (state_q == ST_RUN);
  assign busy         = (state_q != ST_IDLE);
  assign dmaIntFlag   = dma_q;
  assign xferDoneFlag = done_q;

  // R6: a boundary reached with data left pauses and flags
  a_r6_pause_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !(status.lastWord && status.lastBlock) && status.crossBnd)
      |=> (dmaIntFlag && !memReqValid && busy));

  // R14: the final word completes the transfer even on a boundary
  a_r14_final_word_done: assert property (@(posedge clk) disable iff (!rstN)
    (accept && status.lastWord && status.lastBlock)
      |=> (xferDoneFlag && !busy));

  // R7: paused stays paused until the address is rewritten
  a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state_q == ST_PAUSE && !status.addrWrite) |=> (state_q == ST_PAUSE && !memReqValid));

  // R11: a flag survives any write that does not carry a one for it
  a_r11_dma_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (dmaIntFlag && !status.clrDma) |=> dmaIntFlag);

  // R10: zero count start completes without a request
  a_r10_zero_start: assert property (@(posedge clk) disable iff (!rstN)
    (status.startReq && status.startZero && !busy) |=> (xferDoneFlag && !memReqValid));

endmodule

// File: rtl/sdma_bound_engine.sv
module sdma_bound_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int BSIZE_W    = 12,
  parameter int CNT_W      = 16,
  parameter int BND_BASE   = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [2:0]            regWrAddr,
  input  logic [ADDR_W-1:0]     regWrData,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [DATA_BYTES-1:0] memReqStrb,
  output logic                  memReqWrite,
  output logic [CNT_W-1:0]      blocksLeft,
  output logic                  busy,
  output logic                  dmaIntFlag,
  output logic                  xferDoneFlag
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  sdma_datapath #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .BSIZE_W(BSIZE_W),
    .CNT_W(CNT_W), .BND_BASE(BND_BASE)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .ctl(ctl), .status(status),
    .curAddr(memReqAddr), .strb(memReqStrb), .dirRead(memReqWrite),
    .blocksLeft(blocksLeft)
  );

  sdma_control i_control (
    .clk(clk), .rstN(rstN),
    .status(status), .memReqReady(memReqReady),
    .ctl(ctl), .memReqValid(memReqValid), .busy(busy),
    .dmaIntFlag(dmaIntFlag), .xferDoneFlag(xferDoneFlag)
  );

  // R1: quiet out of reset
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

endmodule

// File: tb/test_sdma_bound_engine.sv
`timescale 1ns/100ps
module test_sdma_bound_engine;

  localparam logic [2:0] A_ADDR = 3'd0, A_CFG = 3'd1, A_CNT = 3'd2,
                         A_MODE = 3'd3, A_HOST = 3'd4, A_INT = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic [3:0]  memReqStrb;
  logic        memReqWrite;
  logic [15:0] blocksLeft;
  logic        busy, dmaIntFlag, xferDoneFlag;

  int checks = 0;
  int fails = 0;
  int readyMode = 0;   // 0 always ready, 1 alternate, 2 never
  int acceptCnt = 0;
  logic [31:0] logAddr [64];
  logic [3:0]  logStrb [64];
  logic        logWrite [64];

  always #2.5 clk = ~clk;

  sdma_bound_engine i_sdma_bound_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqStrb(memReqStrb), .memReqWrite(memReqWrite),
    .blocksLeft(blocksLeft), .busy(busy), .dmaIntFlag(dmaIntFlag),
    .xferDoneFlag(xferDoneFlag)
  );

  always @(negedge clk) begin
    if (readyMode == 0)      memReqReady <= 1'b1;
    else if (readyMode == 1) memReqReady <= ~memReqReady;
    else                     memReqReady <= 1'b0;
  end

  always begin
    @(negedge clk);
    #1.5;
    if (memReqValid && memReqReady) begin
      if (acceptCnt < 64) begin
        logAddr[acceptCnt]  = memReqAddr;
        logStrb[acceptCnt]  = memReqStrb;
        logWrite[acceptCnt] = memReqWrite;
      end
      acceptCnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic waitDma();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (dmaIntFlag) break;
    end
  endtask

  task automatic setup(input logic [31:0] addr, input logic [31:0] cfg, input logic [31:0] cnt);
    wr(A_INT, 32'h3);
    wr(A_ADDR, addr);
    wr(A_CFG, cfg);
    wr(A_CNT, cnt);
    acceptCnt = 0;
  endtask

  task automatic t_reset();
    check("R1 valid", {31'b0, memReqValid}, 0);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 flags", {30'b0, dmaIntFlag, xferDoneFlag}, 0);
    check("R1 blocksLeft", {16'b0, blocksLeft}, 0);
  endtask

  task automatic t_single();
    setup(32'h1000_0002, 32'd10, 32'd5);
    wr(A_MODE, 32'h11);  // start, read direction, no counting
    waitIdle();
    check("R3 accepts", acceptCnt, 3);
    check("R3 addr0", logAddr[0], 32'h1000_0000);
    check("R3 addr2", logAddr[2], 32'h1000_0008);
    check("R4 strb0", {28'b0, logStrb[0]}, 4'hF);
    check("R4 tail strb", {28'b0, logStrb[2]}, 4'h3);
    check("R5 dir", {31'b0, logWrite[0]}, 1);
    check("R9 count kept", {16'b0, blocksLeft}, 5);
    check("R2 done", {31'b0, xferDoneFlag}, 1);
  endtask

  task automatic t_multi();
    setup(32'h4000, 32'h7008, 32'd3);
    readyMode = 1;
    wr(A_MODE, 32'h23);
    waitIdle();
    readyMode = 0;
    check("R8 accepts", acceptCnt, 6);
    check("R8 last addr", logAddr[5], 32'h4014);
    check("R4 full strb", {28'b0, logStrb[5]}, 4'hF);
    check("R5 dir write", {31'b0, logWrite[3]}, 0);
    check("R8 count zero", {16'b0, blocksLeft}, 0);
    check("R8 done", {31'b0, xferDoneFlag}, 1);
  endtask

  task automatic t_boundary();
    setup(32'h0FF8, 32'h0010, 32'd1);
    wr(A_MODE, 32'h23);
    waitDma();
    repeat (5) @(negedge clk);
    check("R6 paused accepts", acceptCnt, 2);
    check("R6 busy", {31'b0, busy}, 1);
    check("R6 no valid", {31'b0, memReqValid}, 0);
    check("R6 not done", {31'b0, xferDoneFlag}, 0);
    wr(A_CNT, 32'd9);
    check("R13 count write ignored", {16'b0, blocksLeft}, 1);
    wr(A_INT, 32'h0);
    check("R11 zero write keeps", {31'b0, dmaIntFlag}, 1);
    wr(A_INT, 32'h2);
    check("R11 one write clears", {31'b0, dmaIntFlag}, 0);
    wr(A_ADDR, 32'h2000_0000);
    waitIdle();
    check("R7 accepts", acceptCnt, 4);
    check("R7 resume addr", logAddr[2], 32'h2000_0000);
    check("R7 last addr", logAddr[3], 32'h2000_0004);
    check("R7 done", {31'b0, xferDoneFlag}, 1);
  endtask

  task automatic t_end_on_boundary();
    setup(32'h1FF0, 32'h1010, 32'd1);
    wr(A_MODE, 32'h23);
    waitIdle();
    check("R14 accepts", acceptCnt, 4);
    check("R14 done", {31'b0, xferDoneFlag}, 1);
    check("R14 no dma int", {31'b0, dmaIntFlag}, 0);
  endtask

  task automatic t_big_boundary();
    setup(32'h7FFF8, 32'h7010, 32'd1);
    wr(A_MODE, 32'h23);
    waitDma();
    repeat (3) @(negedge clk);
    check("R6 512K accepts", acceptCnt, 2);
    check("R6 512K last", logAddr[1], 32'h7FFFC);
    wr(A_ADDR, 32'h100);
    waitIdle();
    check("R7 512K resume", logAddr[2], 32'h100);
    check("R7 512K done", {31'b0, xferDoneFlag}, 1);
  endtask

  task automatic t_zero();
    setup(32'h5000, 32'h0008, 32'd0);
    wr(A_MODE, 32'h23);
    @(negedge clk);
    check("R10 done", {31'b0, xferDoneFlag}, 1);
    check("R10 idle", {31'b0, busy}, 0);
    check("R10 accepts", acceptCnt, 0);
  endtask

  task automatic t_dmasel();
    setup(32'h6000, 32'h0008, 32'd1);
    wr(A_HOST, 32'h10);  // select field = 10
    wr(A_MODE, 32'h23);
    repeat (4) @(negedge clk);
    check("R12 idle", {31'b0, busy}, 0);
    check("R12 accepts", acceptCnt, 0);
    check("R12 no done", {31'b0, xferDoneFlag}, 0);
    wr(A_HOST, 32'h0);
  endtask

  task automatic t_addr_running();
    setup(32'h3000, 32'h0008, 32'd1);
    readyMode = 2;
    wr(A_MODE, 32'h23);
    wr(A_ADDR, 32'h5000);
    readyMode = 0;
    waitIdle();
    check("R13 first addr", logAddr[0], 32'h3000);
    check("R13 second addr", logAddr[1], 32'h3004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_boundary();
    t_end_on_boundary();
    t_big_boundary();
    t_zero();
    t_dmasel();
    t_addr_running();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule